// File: doc/BRIEF.md
# Rounding and Saturation Stage

This block finishes a wide signed arithmetic result, such as a product or an accumulator sum, and turns it into a narrower output word. It drops a programmable number of low-order bits. The discarded part can be simply cut off, or it can be rounded by one of two rules: ties move upward, or ties go to the even neighbour.

After rounding, the value can be clamped to the range that the output word can hold. The lower limit is either the full two's-complement minimum or a symmetric limit, which is the negative of the maximum. Because the output always holds the bits that sit above the discard point, the symmetric limits also sit at that point. When saturation is off, the output holds the low bits of the rounded value, which wraps.

The stage is a single register deep. Every input combination yields one output word and one overflow flag on the next clock. The flag is high in exactly the cycles whose result was changed by clamping.

Top module: `round_sat_unit`

## Requirements
- R1: `dout` and `ovf` reflect the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears both to zero on the next edge.
- R2: `rnd_pos` gives the number of low input bits discarded, from 0 up to MAX_SHIFT (24 by default). A code above MAX_SHIFT acts as MAX_SHIFT.
- R3: With `rnd_en` low, the discarded bits are cut off, which rounds toward minus infinity (an arithmetic shift right).
- R4: With `rnd_en` high and `rnd_even` low, the result is the nearest integer, and an exact half rounds toward plus infinity (-4.5 gives -4).
- R5: With `rnd_en` high and `rnd_even` high, the result is the nearest integer, and an exact half goes to the even neighbour (4.5 gives 4, 5.5 gives 6, -5.5 gives -6).
- R6: With `rnd_pos` at 0, no rounding takes place whatever the rounding controls say.
- R7: With `sat_en` high and `sat_sym` low, the rounded value is clamped to the range -2^(OUT_W-1) through 2^(OUT_W-1)-1.
- R8: With `sat_en` high and `sat_sym` high, the lower limit becomes -(2^(OUT_W-1)-1). The output never shows -2^(OUT_W-1) in this mode.
- R9: With `sat_en` low, `dout` is the low OUT_W bits of the rounded value and `ovf` is 0.
- R10: Rounding comes before saturation. A value that rounding carries past the upper limit is clamped.
- R11: `ovf` is 1 exactly when clamping replaced the rounded value with a limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din | input | IN_W (44) | Wide signed value to be reduced |
| rnd_pos | input | SH_W (5) | Count of low bits to discard |
| rnd_en | input | 1 | 1: round the discarded part, 0: cut it off |
| rnd_even | input | 1 | Tie rule: 0 ties upward, 1 ties to even |
| sat_en | input | 1 | 1: clamp to the output range, 0: wrap |
| sat_sym | input | 1 | 1: symmetric lower limit |
| dout | output | OUT_W (18) | Signed result |
| ovf | output | 1 | Result was clamped |

## Verification
The bench uses the default sizes: a 44-bit input, an 18-bit output and a maximum discard of 24 bits. With an 18-bit output, the limits of ±131071 and -131072 can be reached from small input values shifted by two, so ties, clamping and wrap-around can all be worked out by hand. The 24-bit maximum lets one vector hit the largest shift exactly, and a 5-bit position code can also carry 31, which exercises the clamping of the shift amount itself.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  typedef struct packed {
    logic rnd_en;
    logic rnd_even;
    logic sat_en;
    logic sat_sym;
  } rsu_ctrl_t;

  function automatic int shw(input int max_shift);
    return $clog2(max_shift + 1);
  endfunction

endpackage

// File: rtl/rsu_round.sv
module rsu_round #(
  parameter int IN_W      = 44,
  parameter int MAX_SHIFT = 24,
  parameter int SH_W      = 5
) (
  input  logic [IN_W-1:0]        din,
  input  logic [SH_W-1:0]        pos,
  input  logic                   rnd_en,
  input  logic                   rnd_even,
  output logic signed [IN_W:0]   rounded
);

  localparam logic [SH_W-1:0] MAX_SH_V = SH_W'(MAX_SHIFT);
  localparam logic [IN_W-1:0] ONE      = IN_W'(1);

  logic [SH_W-1:0]       sh;
  logic signed [IN_W:0]  ext;
  logic signed [IN_W:0]  floor_v;
  logic [IN_W-1:0]       half_mask;
  logic                  half_bit;
  logic                  sticky;
  logic                  bump;

  always_comb begin
    sh        = (pos > MAX_SH_V) ? MAX_SH_V : pos;
    ext       = $signed({din[IN_W-1], din});
    floor_v   = ext >>> sh;
    half_mask = (sh == '0) ? '0 : (ONE << (sh - SH_W'(1)));
    half_bit  = |(din & half_mask);
    sticky    = (sh == '0) ? 1'b0 : |(din & (half_mask - ONE));
    bump      = rnd_en && half_bit && (!rnd_even || sticky || floor_v[0]);
    rounded   = floor_v + $signed({{IN_W{1'b0}}, bump});
  end

endmodule

// File: rtl/rsu_clamp.sv
module rsu_clamp #(
  parameter int W     = 45,
  parameter int OUT_W = 18
) (
  input  logic signed [W-1:0]  val,
  input  logic                 sat_en,
  input  logic                 sat_sym,
  output logic [OUT_W-1:0]     res,
  output logic                 clipped
);

  localparam logic signed [W-1:0] HI     = {{(W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [W-1:0] LO_ASY = {{(W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic signed [W-1:0] LO_SYM = LO_ASY + W'(1);

  logic signed [W-1:0] lo;

  always_comb begin
    lo      = sat_sym ? LO_SYM : LO_ASY;
    res     = val[OUT_W-1:0];
    clipped = 1'b0;
    if (sat_en) begin
      if (val > HI) begin
        res     = HI[OUT_W-1:0];
        clipped = 1'b1;
      end else if (val < lo) begin
        res     = lo[OUT_W-1:0];
        clipped = 1'b1;
      end
    end
  end

endmodule

// File: rtl/round_sat_unit.sv
module round_sat_unit #(
  parameter int IN_W      = 44,
  parameter int OUT_W     = 18,
  parameter int MAX_SHIFT = 24,
  parameter int SH_W      = rsu_pkg::shw(MAX_SHIFT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   din,
  input  logic [SH_W-1:0]   rnd_pos,
  input  logic              rnd_en,
  input  logic              rnd_even,
  input  logic              sat_en,
  input  logic              sat_sym,
  output logic [OUT_W-1:0]  dout,
  output logic              ovf
);

  localparam int RW = IN_W + 1;

  rsu_pkg::rsu_ctrl_t   ctl;
  logic signed [RW-1:0] rounded;
  logic [OUT_W-1:0]     res_c;
  logic                 clip_c;

  assign ctl = '{rnd_en: rnd_en, rnd_even: rnd_even, sat_en: sat_en, sat_sym: sat_sym};

  rsu_round #(.IN_W(IN_W), .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)) u_round (
    .din      (din),
    .pos      (rnd_pos),
    .rnd_en   (ctl.rnd_en),
    .rnd_even (ctl.rnd_even),
    .rounded  (rounded)
  );

  rsu_clamp #(.W(RW), .OUT_W(OUT_W)) u_clamp (
    .val     (rounded),
    .sat_en  (ctl.sat_en),
    .sat_sym (ctl.sat_sym),
    .res     (res_c),
    .clipped (clip_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      ovf  <= 1'b0;
    end else begin
      dout <= res_c;
      ovf  <= clip_c;
    end
  end

endmodule

// File: rtl/round_sat_unit_chk.sv
module round_sat_unit_chk #(
  parameter int IN_W  = 44,
  parameter int OUT_W = 18,
  parameter int SH_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [IN_W-1:0]   din,
  input logic [SH_W-1:0]   rnd_pos,
  input logic              sat_en,
  input logic              sat_sym,
  input logic [OUT_W-1:0]  dout,
  input logic              ovf
);

  localparam logic [OUT_W-1:0] HI  = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN = {1'b1, {(OUT_W-1){1'b0}}};

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sat_en) |-> !ovf);

  // R7
  ovf_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !$past(sat_sym)) |-> (dout == HI || dout == MIN));

  // R8
  sym_min_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sat_en && sat_sym) |-> (dout != MIN));

  // R6
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!sat_en && rnd_pos == '0) |-> (dout == $past(din[OUT_W-1:0])));

  // R11
  ovf_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && $past(sat_sym)) |-> (dout == HI || dout == MIN + OUT_W'(1)));

endmodule

bind round_sat_unit round_sat_unit_chk #(.IN_W(IN_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .rnd_pos (rnd_pos),
  .sat_en  (sat_en),
  .sat_sym (sat_sym),
  .dout    (dout),
  .ovf     (ovf)
);

// File: tb/sim_round_sat_unit.sv
module sim_round_sat_unit;

  localparam int IN_W = 44;
  localparam int OUT_W = 18;
  localparam int SH_W = 5;
  localparam int NV = 25;

  typedef struct packed {
    logic signed [IN_W-1:0]  din;
    logic [SH_W-1:0]         pos;
    logic                    re;
    logic                    ev;
    logic                    se;
    logic                    sy;
    logic signed [OUT_W-1:0] res;
    logic                    ov;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{22,        2,  0,0,0,0, 5,       0},  // R3 truncate 5.5
    '{22,        2,  1,0,0,0, 6,       0},  // R4
    '{22,        2,  1,1,0,0, 6,       0},  // R5 5.5 -> 6
    '{18,        2,  1,1,0,0, 4,       0},  // R5 4.5 -> 4
    '{18,        2,  1,0,0,0, 5,       0},  // R4 4.5 -> 5
    '{-18,       2,  1,0,0,0, -4,      0},  // R4 -4.5 -> -4
    '{-22,       2,  1,1,0,0, -6,      0},  // R5 -5.5 -> -6
    '{-22,       2,  1,0,0,0, -5,      0},  // R4 -5.5 -> -5
    '{19,        2,  1,1,0,0, 5,       0},  // R5 4.75
    '{17,        2,  1,0,0,0, 4,       0},  // R4 4.25
    '{1234,      0,  1,1,0,0, 1234,    0},  // R6
    '{1048576,   2,  0,0,1,0, 131071,  1},  // R7 high clamp, R11
    '{1048576,   2,  0,0,0,0, 0,       0},  // R9 wrap
    '{-1048576,  2,  0,0,1,0, -131072, 1},  // R7 low clamp
    '{-1048576,  2,  0,0,1,1, -131071, 1},  // R8
    '{-524288,   2,  0,0,1,1, -131071, 1},  // R8 exact minimum
    '{-524288,   2,  0,0,1,0, -131072, 0},  // R7 minimum fits, R11
    '{524286,    2,  1,0,1,0, 131071,  1},  // R10 rounds past limit
    '{524286,    2,  0,0,1,0, 131071,  0},  // R10 truncated fits
    '{8388608,   24, 1,0,0,0, 1,       0},  // R2 max shift 0.5 up
    '{8388608,   24, 1,1,0,0, 0,       0},  // R5 0.5 -> 0
    '{83886080,  31, 1,0,0,0, 5,       0},  // R2 code above max
    '{-22,       2,  0,0,0,0, -6,      0},  // R3 floor
    '{1048576,   2,  0,0,1,1, 131071,  1},  // R8 high side
    '{-1048576,  2,  0,0,0,0, 0,       0}   // R9 wrap, ovf low
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0]  din = '0;
  logic [SH_W-1:0]  rnd_pos = '0;
  logic rnd_en = 1'b0, rnd_even = 1'b0, sat_en = 1'b0, sat_sym = 1'b0;
  logic [OUT_W-1:0] dout;
  logic ovf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  round_sat_unit u0 (
    .clk(clk), .rst(rst), .din(din), .rnd_pos(rnd_pos), .rnd_en(rnd_en),
    .rnd_even(rnd_even), .sat_en(sat_en), .sat_sym(sat_sym), .dout(dout), .ovf(ovf)
  );

  task automatic check(input string tag, input logic [OUT_W-1:0] exp_d, input logic exp_o);
    checks++;
    if (dout !== exp_d || ovf !== exp_o) begin
      errors++;
      $display("FAIL %s: dout=%0d ovf=%0b expected dout=%0d ovf=%0b", tag,
               $signed(dout), ovf, $signed(exp_d), exp_o);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    din = v.din; rnd_pos = v.pos; rnd_en = v.re; rnd_even = v.ev;
    sat_en = v.se; sat_sym = v.sy;
  endtask

  initial begin
    // R1: reset state while inputs are active
    drive(TBL[11]);
    repeat (3) @(posedge clk);
    #1 check("R1 reset", '0, 1'b0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(posedge clk); #1;
      check($sformatf("vector %0d", i), TBL[i].res, TBL[i].ov);
    end

    // R1: one cycle latency, output unchanged before the edge
    drive(TBL[1]);
    @(posedge clk); #1 check("R1 latency a", 18'd6, 1'b0);
    drive(TBL[13]);
    #5 check("R1 latency hold", 18'd6, 1'b0);
    @(posedge clk); #1 check("R1 latency b", TBL[13].res, 1'b1);

    // R1: reset in mid run
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 check("R1 mid reset", '0, 1'b0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1 check("R1 after reset", TBL[13].res, 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule